// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Controller

This block lets software on any of up to four cores raise interrupts on the other cores, or on itself, through one register port. Each core owns a 16-bit register of pending causes. A write to one of sixteen set-only addresses raises one cause bit in every core named by a target mask. A core reads its own pending causes at a single address and acknowledges them there by writing ones. Each core has four interrupt lines. The 16 causes form four groups of unequal width, and a routing register chooses which line each group drives.

Two per-core registers control delivery. The enable register gates all four lines of a core. The assert register forces all four lines of an enabled core high whatever causes are pending. Each of these registers has a read/clear address and a separate write-only set address. The interrupt lines are computed from stored state without a register stage. They therefore follow a register write in the same cycle that the write takes effect.

Top module: `ipi_ctrl`

## Requirements
- R1: After synchronous reset, all cause, enable and assert registers are zero. The routing register reads 0x3201. All interrupt lines are low.
- R2: A write to address 0x140+n (n = 0..15) sets cause bit n in every core c whose bit c of the write data is 1. It changes no other bit.
- R3: A write to address 0x100 clears, in the issuing core's cause register only, each bit written as 1. The cause registers of the other cores are unchanged.
- R4: A read of address 0x100 returns the issuing core's 16 pending cause bits.
- R5: Enable register, one bit per core (bit c = core c): a write to 0x184 sets the bits written as 1. A write to 0x180 clears the bits written as 1. A read of 0x180 returns the register, zero-extended.
- R6: Assert register, same bit layout: 0x18C sets, 0x188 clears, 0x188 reads.
- R7: The routing register at 0x190 is read/write over 16 bits. The 4-bit field at bits [4g+3:4g] belongs to group g. Its low two bits give the line that group drives, and its upper two bits are stored but do not affect routing.
- R8: Cause grouping: group 0 is bit 0, group 1 is bits 1-3, group 2 is bits 4-7, group 3 is bits 8-15.
- R9: Line k of core c is output bit ipi_o[4c+k]. It is high exactly when enable bit c is set and either (a) a pending cause of core c belongs to a group routed to line k, or (b) assert bit c is set.
- R10: Reads of the set-only addresses (0x140-0x14F, 0x184, 0x18C) and of any unmapped address return zero.
- R11: The wake cause is bit 4. A write to 0x144 raises it, and with the reset routing it drives line 2 of each targeted, enabled core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_core | input | 2 | ID of the core issuing the access |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| ipi_o | output | 16 | Interrupt lines, bit 4c+k = line k of core c |

## Verification
The case of interest is a routing write that lands while causes are pending in several cores. In that one cycle, the register write and the line recomputation for every core act together, so each line must move to its new position with no stale or missing pulse. The bench leaves pending causes in three cores and then rewrites the routing register twice. The second rewrite stores nonzero upper field bits. After each write edge the full 16-bit line vector is compared against the value worked out by hand from R7 to R9. The same comparison covers enable and assert writes that change the lines of a core whose causes are already pending.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSES  = 16;
    localparam int GROUPS  = 4;
    localparam int LINES   = 4;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int LINE_W  = $clog2(LINES);

    localparam logic [ADDR_W-1:0] A_CAUSE   = 10'h100;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 10'h180;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 10'h184;
    localparam logic [ADDR_W-1:0] A_AS_CLR  = 10'h188;
    localparam logic [ADDR_W-1:0] A_AS_SET  = 10'h18C;
    localparam logic [ADDR_W-1:0] A_ROUTE   = 10'h190;
    localparam logic [5:0]        A_SET_HI  = 6'h14;

    localparam logic [DATA_W-1:0] ROUTE_INIT = 16'h3201;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CAUSE_CLR,
        OP_CAUSE_SET,
        OP_EN_CLR,
        OP_EN_SET,
        OP_AS_CLR,
        OP_AS_SET,
        OP_ROUTE_WR
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [3:0]        idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [CAUSES-1:0] group_mask(input int g);
        case (g)
            0:       return 16'h0001;
            1:       return 16'h000E;
            2:       return 16'h00F0;
            default: return 16'hFF00;
        endcase
    endfunction

    function automatic op_e addr_op(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:4] == A_SET_HI) return OP_CAUSE_SET;
        case (a)
            A_CAUSE:  return OP_CAUSE_CLR;
            A_EN_CLR: return OP_EN_CLR;
            A_EN_SET: return OP_EN_SET;
            A_AS_CLR: return OP_AS_CLR;
            A_AS_SET: return OP_AS_SET;
            A_ROUTE:  return OP_ROUTE_WR;
            default:  return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output wr_req_t           req
);
    always_comb begin
        req.op   = we ? addr_op(addr) : OP_NONE;
        req.idx  = addr[3:0];
        req.data = wdata;
    end
endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int CW    = $clog2(NCORES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       req,
    input  logic [CW-1:0]                 core,
    output logic [NCORES-1:0][CAUSES-1:0] cause_q
);
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [CAUSES-1:0] nxt;
        always_comb begin
            nxt = cause_q[c];
            if (req.op == OP_CAUSE_SET && req.data[c])
                nxt[req.idx] = 1'b1;
            else if (req.op == OP_CAUSE_CLR && core == CW'(c))
                nxt = cause_q[c] & ~req.data;
        end
        always_ff @(posedge clk) begin
            if (rst) cause_q[c] <= '0;
            else     cause_q[c] <= nxt;
        end
    end
endmodule

// File: rtl/ipi_gate_reg.sv
module ipi_gate_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (set_stb) q <= q | bits;
        else if (clr_stb) q <= q & ~bits;
    end
endmodule

// File: rtl/ipi_router.sv
module ipi_router
    import ipi_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic [NCORES-1:0][CAUSES-1:0] cause,
    input  logic [GROUPS-1:0][LINE_W-1:0] line_of,
    input  logic [NCORES-1:0]             en,
    input  logic [NCORES-1:0]             asg,
    output logic [NCORES*LINES-1:0]       ipi
);
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [LINES-1:0] hit;
        always_comb begin
            hit = '0;
            for (int g = 0; g < GROUPS; g++) begin
                if (|(cause[c] & group_mask(g)))
                    hit[line_of[g]] = 1'b1;
            end
        end
        assign ipi[c*LINES +: LINES] = {LINES{en[c]}} & (hit | {LINES{asg[c]}});
    end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int CW    = $clog2(NCORES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic                      reg_we,
    input  logic [CW-1:0]             reg_core,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [NCORES*LINES-1:0]   ipi_o
);
    wr_req_t                       req;
    logic [NCORES-1:0][CAUSES-1:0] cause_q;
    logic [NCORES-1:0]             en_q;
    logic [NCORES-1:0]             asg_q;
    logic [DATA_W-1:0]             route_q;
    logic [GROUPS-1:0][LINE_W-1:0] line_of;

    ipi_decode u_dec (
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .req   (req)
    );

    ipi_cause_bank #(.NCORES(NCORES)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .core    (reg_core),
        .cause_q (cause_q)
    );

    ipi_gate_reg #(.W(NCORES)) u_en (
        .clk     (clk),
        .rst     (rst),
        .set_stb (req.op == OP_EN_SET),
        .clr_stb (req.op == OP_EN_CLR),
        .bits    (req.data[NCORES-1:0]),
        .q       (en_q)
    );

    ipi_gate_reg #(.W(NCORES)) u_asg (
        .clk     (clk),
        .rst     (rst),
        .set_stb (req.op == OP_AS_SET),
        .clr_stb (req.op == OP_AS_CLR),
        .bits    (req.data[NCORES-1:0]),
        .q       (asg_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                        route_q <= ROUTE_INIT;
        else if (req.op == OP_ROUTE_WR) route_q <= req.data;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_sel
        assign line_of[g] = route_q[4*g +: LINE_W];
    end

    ipi_router #(.NCORES(NCORES)) u_route (
        .cause   (cause_q),
        .line_of (line_of),
        .en      (en_q),
        .asg     (asg_q),
        .ipi     (ipi_o)
    );

    always_comb begin
        case (reg_addr)
            A_CAUSE:  reg_rdata = cause_q[reg_core];
            A_EN_CLR: reg_rdata = {{(DATA_W-NCORES){1'b0}}, en_q};
            A_AS_CLR: reg_rdata = {{(DATA_W-NCORES){1'b0}}, asg_q};
            A_ROUTE:  reg_rdata = route_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int CW    = $clog2(NCORES)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [DATA_W-1:0]             reg_wdata,
    input logic                          reg_we,
    input logic [CW-1:0]                 reg_core,
    input logic [DATA_W-1:0]             reg_rdata,
    input logic [NCORES*LINES-1:0]       ipi_o,
    input logic [NCORES-1:0][CAUSES-1:0] cause_q,
    input logic [NCORES-1:0]             en_q,
    input logic [NCORES-1:0]             asg_q,
    input logic [DATA_W-1:0]             route_q
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (route_q == ROUTE_INIT && en_q == '0 && asg_q == '0 && ipi_o == '0));

    // R3
    a_r3_clear_own: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_CAUSE) |=>
            ((cause_q[$past(reg_core)] & $past(reg_wdata)) == '0));

    // R5
    a_r5_enable_set: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_EN_SET) |=>
            ((en_q & $past(reg_wdata[NCORES-1:0])) == $past(reg_wdata[NCORES-1:0])));

    // R6
    a_r6_assert_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_AS_CLR) |=>
            ((asg_q & $past(reg_wdata[NCORES-1:0])) == '0));

    // R7
    a_r7_route_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_ROUTE) |=> (route_q == $past(reg_wdata)));

    // R10
    a_r10_set_space_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:4] == A_SET_HI || reg_addr == A_EN_SET || reg_addr == A_AS_SET)
            |-> (reg_rdata == '0));

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        // R2
        a_r2_set_targets: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr[ADDR_W-1:4] == A_SET_HI && reg_wdata[c]) |=>
                cause_q[c][$past(reg_addr[3:0])]);
        // R9
        a_r9_gated_off: assert property (@(posedge clk) disable iff (rst)
            !en_q[c] |-> (ipi_o[c*LINES +: LINES] == '0));
        // R9
        a_r9_assert_forces: assert property (@(posedge clk) disable iff (rst)
            (en_q[c] && asg_q[c]) |-> (ipi_o[c*LINES +: LINES] == '1));
    end
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NCORES(NCORES)) chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_core  (reg_core),
    .reg_rdata (reg_rdata),
    .ipi_o     (ipi_o),
    .cause_q   (cause_q),
    .en_q      (en_q),
    .asg_q     (asg_q),
    .route_q   (route_q)
);

// File: tb/ipi_ctrl_test.sv
module ipi_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    typedef struct packed {
        logic        wr;
        logic [1:0]  core;
        logic [9:0]  addr;
        logic [15:0] data;
        logic [15:0] ipi;
        logic [3:0]  req;
    } vec_t;

    // wr, core, addr, data (write data or expected read), expected ipi_o, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 10'h184, 16'h0003, 16'h0000, 4'd5},  // R5 enable cores 0,1
        '{1'b0, 2'd0, 10'h180, 16'h0003, 16'h0000, 4'd5},  // R5 read enable
        '{1'b1, 2'd0, 10'h144, 16'h0001, 16'h0004, 4'd11}, // R11 wake core0 -> line2
        '{1'b1, 2'd1, 10'h140, 16'h0002, 16'h0024, 4'd8},  // R8 group0 -> line1 of core1
        '{1'b1, 2'd0, 10'h14F, 16'h000C, 16'h0024, 4'd9},  // R9 cores 2,3 not enabled
        '{1'b1, 2'd2, 10'h184, 16'h0004, 16'h0824, 4'd9},  // R9 core2 group3 -> line3
        '{1'b0, 2'd2, 10'h100, 16'h8000, 16'h0824, 4'd4},  // R4
        '{1'b0, 2'd3, 10'h100, 16'h8000, 16'h0824, 4'd2},  // R2 broadcast reached core3
        '{1'b0, 2'd0, 10'h100, 16'h0010, 16'h0824, 4'd4},  // R4
        '{1'b1, 2'd0, 10'h142, 16'h0001, 16'h0825, 4'd8},  // R8 bit2 group1 -> line0
        '{1'b1, 2'd0, 10'h100, 16'h0004, 16'h0824, 4'd3},  // R3 clear own
        '{1'b1, 2'd1, 10'h100, 16'h0010, 16'h0824, 4'd3},  // R3 core1 cannot clear core0
        '{1'b0, 2'd0, 10'h100, 16'h0010, 16'h0824, 4'd3},  // R3
        '{1'b1, 2'd0, 10'h190, 16'h0123, 16'h0182, 4'd7},  // R7 reroute with pending
        '{1'b0, 2'd1, 10'h190, 16'h0123, 16'h0182, 4'd7},  // R7 readback
        '{1'b1, 2'd0, 10'h18C, 16'h0008, 16'h0182, 4'd6},  // R6 assert core3, not enabled
        '{1'b1, 2'd0, 10'h184, 16'h0008, 16'hF182, 4'd9},  // R9 assert forces all lines
        '{1'b0, 2'd0, 10'h188, 16'h0008, 16'hF182, 4'd6},  // R6 read assert
        '{1'b1, 2'd0, 10'h188, 16'h0008, 16'h1182, 4'd6},  // R6 clear assert
        '{1'b1, 2'd0, 10'h180, 16'h0001, 16'h1180, 4'd5},  // R5 clear enable core0
        '{1'b0, 2'd0, 10'h180, 16'h000E, 16'h1180, 4'd5},  // R5
        '{1'b0, 2'd0, 10'h145, 16'h0000, 16'h1180, 4'd10}, // R10 set address reads zero
        '{1'b0, 2'd0, 10'h184, 16'h0000, 16'h1180, 4'd10}, // R10
        '{1'b0, 2'd0, 10'h3FF, 16'h0000, 16'h1180, 4'd10}, // R10 unmapped
        '{1'b1, 2'd0, 10'h190, 16'hF0F0, 16'h8810, 4'd7}   // R7 upper field bits ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_core = '0;
    logic [15:0] reg_rdata;
    logic [15:0] ipi_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_core  (reg_core),
        .reg_rdata (reg_rdata),
        .ipi_o     (ipi_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] core, input logic [9:0] a, input logic [15:0] d);
        reg_core = core; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] core, input logic [9:0] a, output logic [15:0] d);
        reg_core = core; reg_addr = a; reg_we = 1'b0;
        #1;
        d = reg_rdata;
    endtask

    task automatic reset_checks(input string when);
        logic [15:0] d;
        check({"R1 ipi ", when}, ipi_o, 16'h0000);
        rd(2'd0, 10'h190, d); check({"R1 route ", when}, d, 16'h3201);
        rd(2'd3, 10'h100, d); check({"R1 cause ", when}, d, 16'h0000);
        rd(2'd0, 10'h180, d); check({"R1 enable ", when}, d, 16'h0000);
        rd(2'd0, 10'h188, d); check({"R1 assert ", when}, d, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R0 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reset_checks("after power-up");

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            if (VEC[i].wr) begin
                wr(VEC[i].core, VEC[i].addr, VEC[i].data);
                check({tag, " ipi"}, ipi_o, VEC[i].ipi);
            end else begin
                rd(VEC[i].core, VEC[i].addr, d);
                check({tag, " rdata"}, d, VEC[i].data);
                check({tag, " ipi"}, ipi_o, VEC[i].ipi);
            end
        end

        // R2 set with empty mask changes nothing
        wr(2'd0, 10'h14A, 16'h0000);
        rd(2'd1, 10'h100, d); check("R2 empty mask", d, 16'h0001);

        // R11 wake to own core with reset routing, line 2
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        reset_checks("after second reset");
        wr(2'd3, 10'h184, 16'h0008);
        wr(2'd3, 10'h144, 16'h0008);
        check("R11 wake line2 core3", ipi_o, 16'h4000);
        wr(2'd3, 10'h100, 16'h0010);
        check("R3 ack wake drops line", ipi_o, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule